// File: doc/BRIEF.md
# Latched-Input Byte-Writable Static Memory

This block is a word-wide static memory with level-transparent input capture in front of the storage array. The address and the two chip selects pass through one capture stage, and the write data passes through a second stage with its own enable. While an enable is high its stage is transparent. While it is low the stage holds what it last saw, so a host can present an address or data once and then reuse the bus pins for something else. With both enables tied high the block acts as an ordinary asynchronous-style memory. Reads are combinational from the effective address, and writes land on the next rising clock edge.

Writes are byte-granular. Each of two active-low strobes gates one byte lane. If write enable is asserted while both strobes stay high, the cycle is an aborted write and leaves the array untouched. The output side has no real tri-state pins. A drive flag stands in for output enable of the pads, and the data bus reads zero whenever the flag is low. The default configuration is a reduced 256-word array. Setting `ADDR_W` to 14 gives the full 16K-word part.

Top module: `lat_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of 2*LANE_W bits each (default 256 x 16; ADDR_W=14 gives 16,384 words), addressed by `addr_i`.
- R2: When `ale_i` is 1, `addr_i`, `sel_i` and `sel_n_i` take effect directly. When `ale_i` is 0, all three are held at the values sampled at the last rising clock edge at which `ale_i` was 1.
- R3: `dle_i` gives the write data the same behaviour. It is transparent at 1 and holds the value from the last edge with `dle_i`=1 when at 0.
- R4: With both enables at 1, a read reflects the current address in the same cycle, and a write is stored at the next rising clock edge.
- R5: The block is selected only when the effective `sel_i`=1 and `sel_n_i`=0. When deselected, `drive_o` is 0 and no write happens.
- R6: A write occurs at a rising edge when the block is selected, `we_n_i`=0 and at least one strobe is low. `bw_lo_n_i`=0 writes bits 7:0 and `bw_hi_n_i`=0 writes bits 15:8. Each lane is written independently.
- R7: With `ale_i` held at 0 and a read in progress, `rdata_o` and `drive_o` stay constant even when the address and select pins change.
- R8: `we_n_i`=0 with both strobes at 1 is an aborted write, and no stored bit changes.
- R9: While `we_n_i`=0, `drive_o` is 0 regardless of `oe_n_i`.
- R10: A selected read (`we_n_i`=1) drives (`drive_o`=1) only when `oe_n_i`=0. When driving, `rdata_o` equals the stored word.
- R11: Whenever `drive_o` is 0, `rdata_o` is all zeros.
- R12: While `rst_n` is 0, `drive_o` is 0. Reset loads the address stage with a deselected state and the data stage with zero, and leaves the array contents as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and stage captures occur on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ale_i | input | 1 | Address/select stage enable, transparent when 1 |
| addr_i | input | ADDR_W | Word address |
| sel_i | input | 1 | Active-high chip select |
| sel_n_i | input | 1 | Active-low chip select |
| dle_i | input | 1 | Write-data stage enable, transparent when 1 |
| wdata_i | input | 2*LANE_W | Write data |
| we_n_i | input | 1 | Active-low write enable |
| bw_lo_n_i | input | 1 | Active-low strobe for the low byte lane |
| bw_hi_n_i | input | 1 | Active-low strobe for the high byte lane |
| oe_n_i | input | 1 | Active-low output enable |
| rdata_o | output | 2*LANE_W | Read data, zero when not driven |
| drive_o | output | 1 | Output-driven flag standing in for the tri-state pins |

## Verification
The hardest case to reach is one where the address pins and the held state disagree. A write or read must go to the held address and held select while the pins already point somewhere else. The stimulus gets there in three steps. It opens the address stage for one edge, closes it, and then moves the pins to a different address and the opposite select polarity. A read and then a write follow in that state. Afterwards the transparent path reads back both the held target and the pin address, which shows which word was touched. The data stage is exercised the same way, by changing the data pins after its enable falls and before the write edge.

// File: rtl/lsram_pkg.sv
package lsram_pkg;

    localparam int ADDR_W_DEF = 8;
    localparam int LANE_W_DEF = 8;
    localparam int LANES      = 2;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE,
        ACC_ABORT
    } acc_kind_e;

endpackage

// File: rtl/lsram_latch.sv
module lsram_latch #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] hold;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.hold = d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hold: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    // transparent while enabled, otherwise the captured value
    assign q = en ? d : st_q.hold;

endmodule

// File: rtl/lsram_ctrl.sv
module lsram_ctrl
    import lsram_pkg::*;
(
    input  logic             rst_n,
    input  logic             sel,
    input  logic             sel_n,
    input  logic             we_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    output acc_kind_e        kind,
    output logic [LANES-1:0] lane_we,
    output logic             drive
);

    logic selected;

    always_comb begin
        selected = rst_n && sel && !sel_n;
        if (!selected) begin
            kind = ACC_IDLE;
        end else if (we_n) begin
            kind = ACC_READ;
        end else if (&bw_n) begin
            kind = ACC_ABORT;
        end else begin
            kind = ACC_WRITE;
        end
        lane_we = (kind == ACC_WRITE) ? ~bw_n : '0;
        drive   = (kind == ACC_READ) && !oe_n;
    end

endmodule

// File: rtl/lsram_lane.sv
module lsram_lane #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem_q [DEPTH];

    // storage is intentionally not reset
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/lat_sram.sv
module lat_sram
    import lsram_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ale_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      sel_i,
    input  logic                      sel_n_i,
    input  logic                      dle_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    input  logic                      we_n_i,
    input  logic                      bw_lo_n_i,
    input  logic                      bw_hi_n_i,
    input  logic                      oe_n_i,
    output logic [LANES*LANE_W-1:0]   rdata_o,
    output logic                      drive_o
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int AST_W  = ADDR_W + 2;
    localparam logic [AST_W-1:0] AST_RST = {{ADDR_W{1'b0}}, 2'b01};

    logic [AST_W-1:0]  ast_pin, ast_eff;
    logic [ADDR_W-1:0] addr_eff;
    logic              sel_eff, sel_n_eff;
    logic [DATA_W-1:0] wdata_eff;
    logic [DATA_W-1:0] word_rd;
    logic [LANES-1:0]  bw_n;
    logic [LANES-1:0]  lane_we;
    logic              drive;
    acc_kind_e         kind;

    assign ast_pin = {addr_i, sel_i, sel_n_i};

    lsram_latch #(.W(AST_W), .RST_VAL(AST_RST)) u_addr_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ale_i),
        .d     (ast_pin),
        .q     (ast_eff)
    );

    assign addr_eff  = ast_eff[AST_W-1:2];
    assign sel_eff   = ast_eff[1];
    assign sel_n_eff = ast_eff[0];

    lsram_latch #(.W(DATA_W), .RST_VAL('0)) u_data_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (dle_i),
        .d     (wdata_i),
        .q     (wdata_eff)
    );

    assign bw_n = {bw_hi_n_i, bw_lo_n_i};

    lsram_ctrl u_ctrl (
        .rst_n   (rst_n),
        .sel     (sel_eff),
        .sel_n   (sel_n_eff),
        .we_n    (we_n_i),
        .bw_n    (bw_n),
        .oe_n    (oe_n_i),
        .kind    (kind),
        .lane_we (lane_we),
        .drive   (drive)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lsram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .we    (lane_we[g]),
            .addr  (addr_eff),
            .wdata (wdata_eff[g*LANE_W +: LANE_W]),
            .rdata (word_rd[g*LANE_W +: LANE_W])
        );
    end

    assign drive_o = drive;
    assign rdata_o = drive ? word_rd : '0;

endmodule

// File: rtl/lsram_chk.sv
module lsram_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale_i,
    input logic              sel_i,
    input logic              sel_n_i,
    input logic              we_n_i,
    input logic              oe_n_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              drive_o
);

    // R5: transparent and deselected pins mean no drive
    a_r5_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_i && !(sel_i && !sel_n_i)) |-> !drive_o);

    // R9: write enable low hides the output
    a_r9_write_hides: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_i |-> !drive_o);

    // R10: output enable high means no drive
    a_r10_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !drive_o);

    // R11: undriven bus reads zero
    a_r11_undriven_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_o |-> (rdata_o == '0));

    // R7: held address during an ongoing read keeps the output steady
    a_r7_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale_i && $past(!ale_i) && we_n_i && $past(we_n_i)
         && !oe_n_i && $past(!oe_n_i))
        |-> ($stable(rdata_o) && $stable(drive_o)));

    // R12: no drive during reset
    a_r12_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> !drive_o);

endmodule

bind lat_sram lsram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_i   (ale_i),
    .sel_i   (sel_i),
    .sel_n_i (sel_n_i),
    .we_n_i  (we_n_i),
    .oe_n_i  (oe_n_i),
    .rdata_o (rdata_o),
    .drive_o (drive_o)
);

// File: tb/tb_lat_sram.sv
module tb_lat_sram;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ale_i, sel_i, sel_n_i, dle_i;
    logic [AW-1:0] addr_i;
    logic [15:0]   wdata_i;
    logic          we_n_i, bw_lo_n_i, bw_hi_n_i, oe_n_i;
    logic [15:0]   rdata_o;
    logic          drive_o;

    logic [15:0] ref_mem [DEPTH];
    int vecs  = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    lat_sram #(.ADDR_W(AW), .LANE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .addr_i(addr_i),
        .sel_i(sel_i), .sel_n_i(sel_n_i), .dle_i(dle_i), .wdata_i(wdata_i),
        .we_n_i(we_n_i), .bw_lo_n_i(bw_lo_n_i), .bw_hi_n_i(bw_hi_n_i),
        .oe_n_i(oe_n_i), .rdata_o(rdata_o), .drive_o(drive_o)
    );

    function automatic logic [15:0] pat(int a, int k);
        return 16'((a * 40503 + k * 7919) ^ 16'h5A5A);
    endfunction

    task automatic chk(string req, logic exp_drv, logic [15:0] exp_dat);
        vecs++;
        if (drive_o !== exp_drv || rdata_o !== exp_dat) begin
            fails++;
            $display("FAIL %s: drive=%0b data=%h, expected drive=%0b data=%h",
                     req, drive_o, rdata_o, exp_drv, exp_dat);
        end
    endtask

    // write through transparent stages; reference updated per lane
    task automatic put(int a, logic [15:0] d, logic lo_n, logic hi_n);
        ale_i = 1; dle_i = 1; sel_i = 1; sel_n_i = 0;
        addr_i = AW'(a); wdata_i = d; oe_n_i = 1;
        we_n_i = 0; bw_lo_n_i = lo_n; bw_hi_n_i = hi_n;
        @(posedge clk); #1;
        we_n_i = 1; bw_lo_n_i = 1; bw_hi_n_i = 1;
        if (!lo_n) ref_mem[a][7:0]  = d[7:0];
        if (!hi_n) ref_mem[a][15:8] = d[15:8];
    endtask

    task automatic look(int a, string req);
        ale_i = 1; sel_i = 1; sel_n_i = 0; addr_i = AW'(a);
        we_n_i = 1; oe_n_i = 0;
        @(negedge clk);
        chk(req, 1'b1, ref_mem[a]);
    endtask

    initial begin
        rst_n = 0; ale_i = 0; dle_i = 0; sel_i = 1; sel_n_i = 0;
        addr_i = '0; wdata_i = '0; we_n_i = 1; bw_lo_n_i = 1; bw_hi_n_i = 1;
        oe_n_i = 0;
        repeat (3) @(negedge clk);
        chk("R12 in reset", 1'b0, 16'h0);
        rst_n = 1;
        @(negedge clk);
        // stage closed since reset: held deselected even though pins select
        chk("R12 held deselect after reset", 1'b0, 16'h0);

        // R1 R4: fill every word, read back transparently
        for (int a = 0; a < DEPTH; a++) put(a, pat(a, 1), 1'b0, 1'b0);
        for (int a = 0; a < DEPTH; a++) look(a, "R4 full-word readback");

        // R6 R8: low lane, high lane, abort, full with new value
        for (int a = 0; a < DEPTH; a++) begin
            case (a % 4)
                0: put(a, pat(a, 2), 1'b0, 1'b1);
                1: put(a, pat(a, 3), 1'b1, 1'b0);
                2: put(a, pat(a, 4), 1'b1, 1'b1);
                default: put(a, pat(a, 5), 1'b0, 1'b0);
            endcase
        end
        for (int a = 0; a < DEPTH; a++) begin
            if (a % 4 == 2) look(a, "R8 abort unchanged");
            else            look(a, "R6 lane write");
        end

        // R10: output enable high
        ale_i = 1; addr_i = 8'd5; oe_n_i = 1; we_n_i = 1;
        @(negedge clk); chk("R10 oe high", 1'b0, 16'h0);
        // R9: write enable low with abort strobes and oe low
        oe_n_i = 0; we_n_i = 0;
        @(negedge clk); chk("R9 we low hides", 1'b0, 16'h0);
        @(posedge clk); #1; we_n_i = 1;
        look(5, "R8 abort with oe low");

        // R5: each deselect polarity, with a write attempt
        for (int k = 0; k < 3; k++) begin
            sel_i = (k == 1); sel_n_i = (k != 0) ? 1'b1 : 1'b0;
            if (k == 0) sel_i = 0;
            addr_i = 8'd9; we_n_i = 1; oe_n_i = 0;
            @(negedge clk); chk("R5 deselected read", 1'b0, 16'h0);
            dle_i = 1; wdata_i = 16'hDEAD; we_n_i = 0;
            bw_lo_n_i = 0; bw_hi_n_i = 0;
            @(posedge clk); #1; we_n_i = 1; bw_lo_n_i = 1; bw_hi_n_i = 1;
            look(9, "R5 deselected write ignored");
        end

        // R2 R7: held address and select, pins moved away
        ale_i = 1; addr_i = 8'd20; sel_i = 1; sel_n_i = 0;
        we_n_i = 1; oe_n_i = 0;
        @(posedge clk); #1;
        ale_i = 0; addr_i = 8'd77; sel_i = 0; sel_n_i = 1;
        @(negedge clk); chk("R7 latched read", 1'b1, ref_mem[20]);
        @(negedge clk); chk("R2 held select", 1'b1, ref_mem[20]);
        // held-address write goes to 20, not 77
        dle_i = 1; wdata_i = 16'hBEEF; we_n_i = 0; bw_lo_n_i = 0; bw_hi_n_i = 0;
        @(posedge clk); #1; we_n_i = 1; bw_lo_n_i = 1; bw_hi_n_i = 1;
        ref_mem[20] = 16'hBEEF;
        look(20, "R2 held-address write target");
        look(77, "R2 pin address untouched");

        // R2: held deselect while pins select
        ale_i = 1; addr_i = 8'd30; sel_i = 0; sel_n_i = 1;
        @(posedge clk); #1;
        ale_i = 0; sel_i = 1; sel_n_i = 0;
        @(negedge clk); chk("R2 held deselect", 1'b0, 16'h0);
        we_n_i = 0; bw_lo_n_i = 0; bw_hi_n_i = 0; wdata_i = 16'h1234;
        @(posedge clk); #1; we_n_i = 1; bw_lo_n_i = 1; bw_hi_n_i = 1;
        look(30, "R2 held deselect blocks write");

        // R3: data stage holds the value seen while open
        dle_i = 1; wdata_i = 16'hA5C3; ale_i = 1; addr_i = 8'd40;
        sel_i = 1; sel_n_i = 0; we_n_i = 1;
        @(posedge clk); #1;
        dle_i = 0; wdata_i = 16'h0F0F;
        we_n_i = 0; bw_lo_n_i = 0; bw_hi_n_i = 0;
        @(posedge clk); #1; we_n_i = 1; bw_lo_n_i = 1; bw_hi_n_i = 1;
        ref_mem[40] = 16'hA5C3;
        look(40, "R3 held write data");
        dle_i = 1;
        put(41, 16'h7E81, 1'b0, 1'b1);
        look(41, "R3 transparent data low lane");

        // R12: reset keeps array contents
        rst_n = 0; @(negedge clk);
        chk("R12 reset drive", 1'b0, 16'h0);
        rst_n = 1;
        look(40, "R12 contents survive reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

endmodule